// File: doc/BRIEF.md
# Serial Configuration Word Router

This block takes configuration words from a three-wire serial port (serial clock, serial data, load strobe) and keeps them in one of several holding registers. The three serial pins are synchronized into the system clock domain, and their edges are detected there. Each rising serial clock edge shifts the data bit into a 21-bit shift register, most significant bit first. When the load strobe rises, the two lowest bits of the word are treated as a selector, and the remaining 19 upper bits are copied into the register that the selector names.

Selector 00 writes the reference divider register. Selector 01 writes the feedback divider register, which holds a swallow field and a main field. Selector 10 writes the function register. Selector 11 also writes the function register, and it raises a one-cycle counter-reset pulse for the downstream counters. After such an initialization write, the block is armed. The next feedback divider write fires the same pulse and disarms it. Any later feedback divider write leaves the pulse low until another initialization write arrives.

Top module: `cfg_word_router`

## Requirements
- R1: Each rising serial clock edge shifts in one data bit, MSB first. When more than 21 bits come before a load, only the last 21 bits are used.
- R2: Selector 00 (word bits 1:0) copies word bits 20:2 to `ref_latch`. `ref_div` shows word bits 15:2.
- R3: Selector 01 copies word bits 20:2 to `n_latch`. `n_a` shows word bits 6:2 and `n_b` shows word bits 19:7.
- R4: Selector 10 copies word bits 20:2 to `func_latch` and does not raise `cnt_rst`.
- R5: Selector 11 copies word bits 20:2 to `func_latch` and raises `cnt_rst` for exactly one system clock cycle. The pulse comes from a load strobe that rose 3 system clock cycles earlier.
- R6: The first selector-01 write after a selector-11 write raises `cnt_rst` for one cycle. The selector-01 writes after it do not.
- R7: After reset, and before any initialization write, a selector-01 write does not raise `cnt_rst`.
- R8: A load changes only the register it selects. The other registers keep their values.
- R9: Shifting bits without a rising load strobe changes none of the registers.
- R10: After reset, all registers read zero and `cnt_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, acts on its rising edge |
| ref_latch | output | 19 | Reference divider register |
| n_latch | output | 19 | Feedback divider register |
| func_latch | output | 19 | Function register |
| ref_div | output | 14 | Reference divide value field |
| n_a | output | 5 | Swallow count field |
| n_b | output | 13 | Main count field |
| cnt_rst | output | 1 | One-cycle counter-reset pulse |

## Verification
A pin change takes two synchronizer stages and one register before it has an effect. A rising load strobe that is set up before system edge k therefore updates the registers and `cnt_rst` at edge k+2. The bench changes the pins only on falling system clock edges and holds every serial level for several cycles. It checks the registers only after the load strobe has fallen and eight more cycles have passed. It counts `cnt_rst` high cycles over the whole window after each load, so that the exact count (zero or one) is checked and not a single sample. The checker ties each pulse and each register change to a load strobe rise exactly three cycles earlier.

// File: rtl/cfg_word_router.sv
module cfg_word_router #(
  parameter int SR_W   = 21,
  parameter int REF_W  = 14,
  parameter int A_W    = 5,
  parameter int B_W    = 13,
  parameter int SYNC_N = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk,
  input  logic                  ser_dat,
  input  logic                  ser_load,
  output logic [SR_W-3:0]       ref_latch,
  output logic [SR_W-3:0]       n_latch,
  output logic [SR_W-3:0]       func_latch,
  output logic [REF_W-1:0]      ref_div,
  output logic [A_W-1:0]        n_a,
  output logic [B_W-1:0]        n_b,
  output logic                  cnt_rst
);
  localparam int CTRL_W = 2;
  localparam int PAY_W  = SR_W - CTRL_W;
  localparam int HIST   = SYNC_N + 1;

  typedef enum logic [CTRL_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_N    = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } sel_e;

  logic [HIST-1:0]  clk_s, dat_s, ld_s;
  logic [SR_W-1:0]  shreg;
  logic             armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_s <= '0;
      dat_s <= '0;
      ld_s  <= '0;
    end else begin
      clk_s <= {clk_s[HIST-2:0], ser_clk};
      dat_s <= {dat_s[HIST-2:0], ser_dat};
      ld_s  <= {ld_s[HIST-2:0], ser_load};
    end
  end

  wire sclk_rise = clk_s[SYNC_N-1] & ~clk_s[SYNC_N];
  wire load_rise = ld_s[SYNC_N-1] & ~ld_s[SYNC_N];
  wire bit_in    = dat_s[SYNC_N-1];

  wire sel_e             sel     = sel_e'(shreg[CTRL_W-1:0]);
  wire logic [PAY_W-1:0] payload = shreg[SR_W-1:CTRL_W];

  always_ff @(posedge clk) begin
    if (!rst_n)         shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[SR_W-2:0], bit_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_latch  <= '0;
      n_latch    <= '0;
      func_latch <= '0;
      armed      <= 1'b0;
      cnt_rst    <= 1'b0;
    end else begin
      cnt_rst <= 1'b0;
      if (load_rise) begin
        case (sel)
          SEL_REF:  ref_latch <= payload;
          SEL_N: begin
            n_latch <= payload;
            if (armed) begin
              cnt_rst <= 1'b1;
              armed   <= 1'b0;
            end
          end
          SEL_FUNC: func_latch <= payload;
          SEL_INIT: begin
            func_latch <= payload;
            cnt_rst    <= 1'b1;
            armed      <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign ref_div = ref_latch[REF_W-1:0];
  assign n_a     = n_latch[A_W-1:0];
  assign n_b     = n_latch[A_W +: B_W];
endmodule

// File: rtl/cfg_word_router_chk.sv
module cfg_word_router_chk #(
  parameter int PAY_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_load,
  input logic             cnt_rst,
  input logic [PAY_W-1:0] ref_latch,
  input logic [PAY_W-1:0] n_latch,
  input logic [PAY_W-1:0] func_latch
);
  assert_pulse_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !cnt_rst);

  assert_pulse_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |-> ($past(ser_load, 3) && !$past(ser_load, 4)));

  assert_ref_only_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_latch) |-> ($past(ser_load, 3) && !$past(ser_load, 4)));

  assert_n_only_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_latch) |-> ($past(ser_load, 3) && !$past(ser_load, 4)));

  assert_func_only_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(func_latch) |-> ($past(ser_load, 3) && !$past(ser_load, 4)));
endmodule

bind cfg_word_router cfg_word_router_chk #(.PAY_W(SR_W-2)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_load(ser_load), .cnt_rst(cnt_rst),
  .ref_latch(ref_latch), .n_latch(n_latch), .func_latch(func_latch)
);

// File: tb/cfg_word_router_test.sv
module cfg_word_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam logic [20:0] VEC [NVEC] = '{
    {19'h01234, 2'b00},
    {19'h5A5A5, 2'b01},
    {19'h3C3C3, 2'b10},
    {19'h0F0F0, 2'b11},
    {19'h12345, 2'b01},
    {19'h7FFFF, 2'b01},
    {19'h00001, 2'b10},
    {19'h11111, 2'b11},
    {19'h7FFFF, 2'b00},
    {19'h00000, 2'b01}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_load = 1'b0;
  logic [18:0] ref_latch, n_latch, func_latch;
  logic [13:0] ref_div;
  logic [4:0]  n_a;
  logic [12:0] n_b;
  logic        cnt_rst;

  int checks = 0, fails = 0, pulses = 0, cyc = 0;
  logic [18:0] e_ref = '0, e_n = '0, e_func = '0;
  logic        e_armed = 1'b0;

  cfg_word_router uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_load(ser_load),
    .ref_latch(ref_latch), .n_latch(n_latch), .func_latch(func_latch),
    .ref_div(ref_div), .n_a(n_a), .n_b(n_b), .cnt_rst(cnt_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && cnt_rst) pulses <= pulses + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles, exp fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_dat = w[i];
      wait_cyc(4); ser_clk = 1'b1;
      wait_cyc(4); ser_clk = 1'b0;
      wait_cyc(4);
    end
  endtask

  task automatic strobe();
    @(negedge clk); pulses = 0;
    ser_load = 1'b1; wait_cyc(4);
    ser_load = 1'b0; wait_cyc(8);
  endtask

  task automatic model(input logic [20:0] w, output int exp_p);
    exp_p = 0;
    case (w[1:0])
      2'b00: e_ref = w[20:2];
      2'b01: begin e_n = w[20:2]; if (e_armed) begin exp_p = 1; e_armed = 1'b0; end end
      2'b10: e_func = w[20:2];
      default: begin e_func = w[20:2]; exp_p = 1; e_armed = 1'b1; end
    endcase
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 ref_latch"}, 32'(ref_latch), 32'(e_ref));
    chk({tag, " R2 ref_div"}, 32'(ref_div), 32'(e_ref[13:0]));
    chk({tag, " R3 n_latch"}, 32'(n_latch), 32'(e_n));
    chk({tag, " R3 n_a"}, 32'(n_a), 32'(e_n[4:0]));
    chk({tag, " R3 n_b"}, 32'(n_b), 32'(e_n[17:5]));
    chk({tag, " R4 func_latch"}, 32'(func_latch), 32'(e_func));
  endtask

  initial begin
    int ep;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    check_all("R10 reset");
    chk("R10 cnt_rst", 32'(cnt_rst), 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      send_bits(32'(VEC[k]), 21);
      strobe();
      model(VEC[k], ep);
      check_all($sformatf("R8 vec%0d", k));
      chk($sformatf("R5 R6 R7 pulse count vec%0d", k), 32'(pulses), 32'(ep));
    end

    send_bits(32'h1F, 5);
    send_bits(32'({19'h2AAAA, 2'b00}), 21);
    strobe();
    model({19'h2AAAA, 2'b00}, ep);
    chk("R1 extra bits dropped ref", 32'(ref_latch), 32'h2AAAA);

    pulses = 0;
    send_bits(32'({19'h55555, 2'b11}), 21);
    wait_cyc(8);
    check_all("R9 no load");
    chk("R9 no pulse", 32'(pulses), 32'd0);

    strobe();
    model({19'h55555, 2'b11}, ep);
    check_all("R5 init");
    chk("R5 init pulse", 32'(pulses), 32'd1);

    send_bits(32'({19'h00ABC, 2'b10}), 21);
    strobe();
    model({19'h00ABC, 2'b10}, ep);
    chk("R4 func no pulse", 32'(pulses), 32'd0);
    send_bits(32'({19'h06789, 2'b01}), 21);
    strobe();
    model({19'h06789, 2'b01}, ep);
    chk("R6 armed across func write", 32'(pulses), 32'd1);
    check_all("R6 after n");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule